// File: doc/BRIEF.md
# Phase-Shift Full-Bridge Gate Sequencer

This block generates the four primary-side gate commands of a phase-shifted full-bridge converter from a digital clock. A cycle counter stands in for an oscillator. One oscillator cycle lasts `HALF_CYC` clocks, and each bridge leg completes one switching period every two cycles. The lead leg (gates A and B) swaps its conducting side at the start of every cycle. The lag leg (gates C and D) swaps its side later in the same cycle, at a point set by a phase command. Each leg has its own programmable dead time, during which both of its gates are low.

A current-limit strobe can end the active half cycle early by swapping the lag leg before the phase point. The phase and dead-time words are captured once per cycle, at the cycle boundary, so a command that changes mid-cycle cannot cut a pulse short. A one-clock pulse marks the start of each cycle. Dropping the enable forces every output low at once. After the enable is raised again, the first half cycle always gives the lead leg to gate A.

Top module: `psfb_sequencer`

## Requirements
- R1: While `rst_n` is low, or in any cycle where `enable` is low, all four gates and `cycleStart` are low. Dropping `enable` takes effect in the same cycle, with no clock edge needed.
- R2: At the first clock edge that samples `enable` high after a low period, the count restarts at position 0 and `cycleStart` is high for that cycle. That first cycle is always an A cycle: gate A is the lead side.
- R3: The count runs through positions 0 to `HALF_CYC`-1 and then wraps. The lead side alternates A, B, A, ... on successive cycles. Gate B is never high during an A cycle, and gate A is never high during a B cycle.
- R4: In each cycle, the lead-side gate rises at position min(`deadLead`, `HALF_CYC`/2-1) and stays high to the end of the cycle. The gate that was high at the end of the previous cycle is low from position 0.
- R5: The lag leg swaps sides at position P = min(`phaseCmd`, floor(`HALF_CYC`*97/100)). In an A cycle the new side is gate D; in a B cycle it is gate C. Both lag gates are low from position P.
- R6: A phase command above floor(`HALF_CYC`*97/100) is clamped to that value, and a dead-time word above `HALF_CYC`/2-1 is clamped to `HALF_CYC`/2-1.
- R7: The new lag-leg gate rises min(`deadLag`, `HALF_CYC`/2-1) clocks after the swap. If no swap has happened since the last enable, gate C is the lag side and rises that many clocks after position 0.
- R8: `phaseCmd`, `deadLead` and `deadLag` are sampled only on the clock edge that enters position 0. A change at any other time has no effect until the next cycle start.
- R9: If `termStrobe` is sampled high at a clock edge that stays within the current cycle, and the lag leg has not yet swapped in that cycle, the lag leg swaps on that edge. It then does not swap again at P. A strobe that arrives after the swap in the same cycle has no effect.
- R10: Gates A and B are never high together, and gates C and D are never high together.
- R11: `cycleStart` is high exactly at position 0 of every cycle while running, so it pulses once every `HALF_CYC` clocks and for one clock each time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low forces all outputs low at once |
| phaseCmd | input | CMD_W | Lag-leg swap position within a cycle, in clocks |
| deadLead | input | DT_W | Dead time of the A/B leg, in clocks |
| deadLag | input | DT_W | Dead time of the C/D leg, in clocks |
| termStrobe | input | 1 | Current-limit request to swap the lag leg early |
| gateA | output | 1 | Lead leg, high-side gate |
| gateB | output | 1 | Lead leg, low-side gate |
| gateC | output | 1 | Lag leg, gate paired with the B cycle |
| gateD | output | 1 | Lag leg, gate paired with the A cycle |
| cycleStart | output | 1 | One-clock pulse at position 0 of every cycle |

## Verification
A count or lead-side error shows within one cycle: the spacing between start pulses shifts, the lead gate rises at the wrong position, or gate B appears inside an A cycle. A stale or wrongly clamped phase or dead-time latch shifts the first-high position of gate A or gate D inside the measured A cycle, so it shows in the first full cycle after the change should have applied. A stuck or wrongly cleared swap flag lets the lag leg flip twice in one cycle, so gate C reappears after a current-limit swap before that cycle ends.

// File: rtl/psfb_pkg.sv
package psfb_pkg;

  // Strobes from the cycle controller to the lag-leg datapath.
  typedef struct packed {
    logic runNow;     // sequencer running this cycle
    logic leadIsA;    // lead side this cycle is gate A
    logic leadOpen;   // lead dead time has elapsed this cycle
    logic runNext;    // running after the coming edge
    logic startNext;  // coming edge enters position 0
    logic leadIsANext;
    logic phaseHitNext; // coming edge lands on the phase point
  } seqStrobe_t;

endpackage

// File: rtl/psfb_seq_ctrl.sv
module psfb_seq_ctrl
  import psfb_pkg::*;
#(
  parameter int HALF_CYC = 20,
  parameter int CMD_W    = 8,
  parameter int DT_W     = 6,
  parameter int CW       = $clog2(HALF_CYC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [CMD_W-1:0] phaseCmd,
  input  logic [DT_W-1:0] deadLead,
  input  logic [DT_W-1:0] deadLag,
  output seqStrobe_t      strb,
  output logic [CW-1:0]   deadLagLat,
  output logic            cycleStart
);

  localparam int PH_MAX = (HALF_CYC * 97) / 100;
  localparam int DT_MAX = HALF_CYC / 2 - 1;
  localparam logic [CW-1:0] LAST_POS = CW'(HALF_CYC - 1);

  logic          running;
  logic [CW-1:0] pos;
  logic          leadIsA;
  logic [CW-1:0] phaseLat;
  logic [CW-1:0] deadLeadLat;

  logic [CW-1:0] posNext;
  logic          leadIsANext;
  logic          loadCmds;
  logic [CW-1:0] phaseClamped;
  logic [CW-1:0] leadClamped;
  logic [CW-1:0] lagClamped;
  logic [CW-1:0] phaseNext;
  logic [CW-1:0] deadLeadNext;
  logic [CW-1:0] deadLagNext;

  // Command clamping (R6)
  always_comb begin
    phaseClamped = (phaseCmd > CMD_W'(PH_MAX)) ? CW'(PH_MAX) : CW'(phaseCmd);
    leadClamped  = (deadLead > DT_W'(DT_MAX))  ? CW'(DT_MAX) : CW'(deadLead);
    lagClamped   = (deadLag  > DT_W'(DT_MAX))  ? CW'(DT_MAX) : CW'(deadLag);
  end

  // Next-state of the cycle counter and lead polarity (R2, R3)
  always_comb begin
    if (!running || !enable) begin
      posNext     = '0;
      leadIsANext = 1'b1;
    end else if (pos == LAST_POS) begin
      posNext     = '0;
      leadIsANext = ~leadIsA;
    end else begin
      posNext     = pos + 1'b1;
      leadIsANext = leadIsA;
    end
    // Commands are captured only on the edge entering position 0 (R8)
    loadCmds     = !running || !enable || (pos == LAST_POS);
    phaseNext    = loadCmds ? phaseClamped : phaseLat;
    deadLeadNext = loadCmds ? leadClamped  : deadLeadLat;
    deadLagNext  = loadCmds ? lagClamped   : deadLagLat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running     <= 1'b0;
      pos         <= '0;
      leadIsA     <= 1'b1;
      phaseLat    <= '0;
      deadLeadLat <= '0;
      deadLagLat  <= '0;
    end else begin
      running     <= enable;
      pos         <= posNext;
      leadIsA     <= leadIsANext;
      phaseLat    <= phaseNext;
      deadLeadLat <= deadLeadNext;
      deadLagLat  <= deadLagNext;
    end
  end

  always_comb begin
    strb.runNow       = running;
    strb.leadIsA      = leadIsA;
    strb.leadOpen     = (pos >= deadLeadLat);
    strb.runNext      = enable;
    strb.startNext    = enable && (posNext == '0);
    strb.leadIsANext  = leadIsANext;
    strb.phaseHitNext = enable && (posNext == phaseNext);
    cycleStart        = enable && running && (pos == '0);
  end

endmodule

// File: rtl/psfb_lag_datapath.sv
module psfb_lag_datapath
  import psfb_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          termStrobe,
  input  seqStrobe_t    strb,
  input  logic [CW-1:0] deadLagLat,
  output logic          gateA,
  output logic          gateB,
  output logic          gateC,
  output logic          gateD
);

  logic          lagOnD;     // lag leg currently assigned to gate D
  logic [CW-1:0] lagTimer;   // clocks since the last lag swap, saturating
  logic          swapped;    // lag leg already swapped this cycle

  logic swappedBase;
  logic swapNow;
  logic live;

  always_comb begin
    swappedBase = strb.startNext ? 1'b0 : swapped;
    swapNow     = strb.runNext && !swappedBase &&
                  (strb.phaseHitNext || (termStrobe && strb.runNow));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lagOnD   <= 1'b0;
      lagTimer <= '0;
      swapped  <= 1'b0;
    end else if (!strb.runNext) begin
      lagOnD   <= 1'b0;
      lagTimer <= '0;
      swapped  <= 1'b0;
    end else if (swapNow) begin
      lagOnD   <= strb.leadIsANext;
      lagTimer <= '0;
      swapped  <= 1'b1;
    end else if (!strb.runNow) begin
      lagTimer <= '0;
      swapped  <= 1'b0;
    end else begin
      if (lagTimer != '1) lagTimer <= lagTimer + 1'b1;
      swapped <= swappedBase;
    end
  end

  always_comb begin
    live  = enable && strb.runNow;
    gateA = live &&  strb.leadIsA && strb.leadOpen;
    gateB = live && !strb.leadIsA && strb.leadOpen;
    gateC = live && !lagOnD && (lagTimer >= deadLagLat);
    gateD = live &&  lagOnD && (lagTimer >= deadLagLat);
  end

endmodule

// File: rtl/psfb_sequencer.sv
module psfb_sequencer
  import psfb_pkg::*;
#(
  parameter int HALF_CYC = 20,
  parameter int CMD_W    = 8,
  parameter int DT_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CMD_W-1:0] phaseCmd,
  input  logic [DT_W-1:0]  deadLead,
  input  logic [DT_W-1:0]  deadLag,
  input  logic             termStrobe,
  output logic             gateA,
  output logic             gateB,
  output logic             gateC,
  output logic             gateD,
  output logic             cycleStart
);

  localparam int CW = $clog2(HALF_CYC);

  seqStrobe_t    strb;
  logic [CW-1:0] deadLagLat;

  psfb_seq_ctrl #(
    .HALF_CYC(HALF_CYC), .CMD_W(CMD_W), .DT_W(DT_W), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .phaseCmd(phaseCmd), .deadLead(deadLead), .deadLag(deadLag),
    .strb(strb), .deadLagLat(deadLagLat), .cycleStart(cycleStart)
  );

  psfb_lag_datapath #(.CW(CW)) u_dp (
    .clk(clk), .rst_n(rst_n), .enable(enable), .termStrobe(termStrobe),
    .strb(strb), .deadLagLat(deadLagLat),
    .gateA(gateA), .gateB(gateB), .gateC(gateC), .gateD(gateD)
  );

endmodule

// File: rtl/psfb_checker.sv
module psfb_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic gateA,
  input logic gateB,
  input logic gateC,
  input logic gateD,
  input logic cycleStart
);

  assert_lead_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(gateA && gateB));

  assert_lag_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(gateC && gateD));

  assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !(gateA || gateB || gateC || gateD || cycleStart));

  assert_start_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cycleStart |=> !cycleStart);

  assert_a_drops_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cycleStart && $past(gateA)) |-> !gateA);

  assert_b_drops_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cycleStart && $past(gateB)) |-> !gateB);

endmodule

bind psfb_sequencer psfb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .gateA(gateA), .gateB(gateB), .gateC(gateC), .gateD(gateD),
  .cycleStart(cycleStart)
);

// File: tb/tb_psfb_sequencer.sv
module tb_psfb_sequencer;

  localparam int HALF = 20;
  localparam int PMAX = (HALF * 97) / 100;
  localparam int DMAX = HALF / 2 - 1;
  localparam int NVEC = 6;
  // {phaseCmd, deadLead, deadLag}
  localparam int VEC [NVEC][3] = '{
    '{0, 0, 0}, '{5, 2, 3}, '{10, 9, 9},
    '{200, 50, 0}, '{12, 0, 4}, '{3, 7, 1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       termStrobe = 1'b0;
  logic [7:0] phaseCmd = '0;
  logic [5:0] deadLead = '0;
  logic [5:0] deadLag = '0;
  logic gateA, gateB, gateC, gateD, cycleStart;

  int nRun = 0;
  int nFail = 0;
  int aRise, dRise, bRise, bCount, cLate, len;

  psfb_sequencer #(.HALF_CYC(HALF), .CMD_W(8), .DT_W(6)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .phaseCmd(phaseCmd),
    .deadLead(deadLead), .deadLag(deadLag), .termStrobe(termStrobe),
    .gateA(gateA), .gateB(gateB), .gateC(gateC), .gateD(gateD),
    .cycleStart(cycleStart)
  );

  always #10 clk = ~clk;

  function automatic int clampTo(int v, int m);
    return (v > m) ? m : v;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
  endtask

  task automatic nextStart();
    do @(negedge clk); while (!cycleStart);
  endtask

  // Restart with new commands; returns at position 0 of the first (A) cycle.
  task automatic startRun(input int p, input int dl, input int dg);
    @(negedge clk);
    enable = 1'b0;
    phaseCmd = 8'(p);
    deadLead = 6'(dl);
    deadLag = 6'(dg);
    @(negedge clk);
    enable = 1'b1;
    nextStart();
  endtask

  // Called at position 0 of an A cycle; ends at position 0 of the next cycle.
  task automatic measureA();
    aRise = -1; dRise = -1; bCount = 0;
    for (int i = 0; i < HALF; i++) begin
      if (i > 0) @(negedge clk);
      if (gateA && aRise < 0) aRise = i;
      if (gateD && dRise < 0) dRise = i;
      if (gateB) bCount++;
    end
    @(negedge clk);
    len = cycleStart ? HALF : -1;
  endtask

  initial begin
    // R1: outputs quiet in reset even with enable high
    enable = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!(gateA || gateB || gateC || gateD || cycleStart), "R1 reset quiet",
            {gateA, gateB, gateC, gateD, cycleStart}, 0);
    end
    enable = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: R3 R4 R5 R6 R7 R11 in the second A cycle
    for (int v = 0; v < NVEC; v++) begin
      startRun(VEC[v][0], VEC[v][1], VEC[v][2]);
      nextStart();
      nextStart();
      measureA();
      check(aRise == clampTo(VEC[v][1], DMAX), "R4/R6 lead rise", aRise,
            clampTo(VEC[v][1], DMAX));
      check(dRise == clampTo(VEC[v][0], PMAX) + clampTo(VEC[v][2], DMAX),
            "R5/R7 lag D rise", dRise,
            clampTo(VEC[v][0], PMAX) + clampTo(VEC[v][2], DMAX));
      check(bCount == 0, "R3 B quiet in A cycle", bCount, 0);
      check(len == HALF, "R11 cycle length", len, HALF);
    end

    // R2 polarity and R3 alternation
    startRun(8, 0, 0);
    check(cycleStart && gateA && !gateB, "R2 first cycle is A",
          {cycleStart, gateA, gateB}, 3'b110);
    nextStart();
    check(gateB && !gateA, "R3 second cycle is B", {gateA, gateB}, 2'b01);
    repeat (3) @(negedge clk);
    enable = 1'b0;
    #1;
    check(!(gateA || gateB || gateC || gateD || cycleStart), "R1 immediate off",
          {gateA, gateB, gateC, gateD, cycleStart}, 0);
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check(cycleStart && gateA && !gateB, "R2 re-enable starts A",
          {cycleStart, gateA, gateB}, 3'b110);

    // R8: mid-cycle command changes wait for the next start
    startRun(10, 2, 2);
    nextStart();
    nextStart();
    dRise = -1;
    for (int i = 0; i < HALF; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 3) begin
        phaseCmd = 8'd4;
        deadLead = 6'd5;
      end
      if (gateD && dRise < 0) dRise = i;
    end
    check(dRise == 12, "R8 old phase kept", dRise, 12);
    @(negedge clk);
    bRise = -1;
    for (int i = 0; i < HALF; i++) begin
      if (i > 0) @(negedge clk);
      if (gateB && bRise < 0) bRise = i;
    end
    check(bRise == 5, "R8 new lead dead time next cycle", bRise, 5);
    @(negedge clk);
    measureA();
    check(dRise == 6, "R8 new phase next cycle", dRise, 6);

    // R9: current-limit strobe swaps the lag leg early, once per cycle
    startRun(15, 0, 2);
    nextStart();
    nextStart();
    dRise = -1; cLate = 0;
    for (int i = 0; i < HALF; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 5) termStrobe = 1'b1;
      if (i == 6) termStrobe = 1'b0;
      if (gateD && dRise < 0) dRise = i;
      if (i >= 6 && gateC) cLate++;
    end
    check(dRise == 8, "R9 early swap", dRise, 8);
    check(cLate == 0, "R9 no second swap at phase point", cLate, 0);
    nextStart();
    nextStart();
    cLate = 0; dRise = -1;
    for (int i = 0; i < HALF; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 17) termStrobe = 1'b1;
      if (i == 18) termStrobe = 1'b0;
      if (gateD && dRise < 0) dRise = i;
      if (i >= 18 && (gateC || !gateD)) cLate++;
    end
    termStrobe = 1'b0;
    check(dRise == 17, "R9 phase swap before strobe", dRise, 17);
    check(cLate == 0, "R9 late strobe ignored", cLate, 0);

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog R11 actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

endmodule